// File: doc/BRIEF.md
# Segment Offset Translator and Access Checker

This block turns a segment-relative offset into a 32-bit linear address and checks the access against a descriptor that has already been loaded into a cache. The inputs are the cached base, a 20-bit limit, the granularity and default-size flags, and the 8-bit rights byte. The access itself is given as an offset, a width and a kind (read, write or instruction fetch). The block does not fetch descriptors, translate pages, compare privilege levels or raise exceptions. It only reports a fault flag and a 3-bit cause code that the surrounding logic acts on.

The rights byte fields that the block reads sit at fixed positions. Bit 7 is the present flag. Bit 3 is the code/data flag. Bit 2 is expand-down for a data segment. Bit 1 is writable for a data segment and readable for a code segment. All other bits are ignored. The linear address and the check result go through one output register, so each access reports its result one clock after it is presented.

Top module: `seg_guard`

## Requirements
- R1: `lin_addr` equals `seg_base + acc_offset` modulo 2^32. It appears on the clock edge after the inputs are sampled, and it is produced for every access whether or not it faults.
- R2: While `rst_n` is low, `lin_addr`, `fault` and `fault_code` are all zero.
- R3: When `seg_gran` is 0, the effective limit is the 20-bit `seg_limit`, zero-extended and counted in bytes.
- R4: When `seg_gran` is 1, the effective limit is `seg_limit` followed by twelve 1 bits, which counts in 4 KB units.
- R5: `acc_size` selects a width of 1, 2, 4 or 8 bytes for codes 0, 1, 2 and 3. In an expand-up segment, the access faults with code 2 (limit) when its last byte (`acc_offset` + width − 1, computed without wrap) is above the effective limit.
- R6: A data segment with rights bit 2 set is expand-down. Its accesses fault with code 2 when `acc_offset` is at or below the effective limit. They also fault with code 2 when the last byte is above the upper bound, which is 0xFFFF if `seg_big` is 0 and 0xFFFFFFFF if `seg_big` is 1.
- R7: If rights bit 7 (present) is 0, every access faults with code 1, whatever the other inputs are.
- R8: In a code segment (rights bit 3 set), a write faults with code 3, a read faults with code 4 when rights bit 1 is 0, and a fetch is always permitted.
- R9: In a data segment (rights bit 3 clear), a write faults with code 3 when rights bit 1 is 0, and a fetch always faults with code 5.
- R10: `acc_kind` is 0 for read, 1 for write and 2 for fetch, and 3 behaves as a read. Only one cause is reported, checked in this order: not present, then type or permission, then limit. `fault` is 1 exactly when `fault_code` is nonzero, and code 0 means no fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| seg_base | input | 32 | Cached segment base |
| seg_limit | input | 20 | Cached segment limit |
| seg_gran | input | 1 | Limit granularity (0 bytes, 1 4 KB units) |
| seg_big | input | 1 | Default size flag, sets the expand-down upper bound |
| seg_rights | input | 8 | Rights byte |
| acc_offset | input | 32 | Offset inside the segment |
| acc_size | input | 2 | Width code, 1 << code bytes |
| acc_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 read |
| lin_addr | output | 32 | Registered linear address |
| fault | output | 1 | Registered fault flag |
| fault_code | output | 3 | Registered cause: 0 none, 1 not present, 2 limit, 3 write, 4 read, 5 execute |

## Verification
The assertions assume the inputs are steady at each sampling edge. They compare each output with the inputs from the previous edge only after one clocked cycle outside reset, so the first result after reset release is never checked against inputs that were sampled during reset. The stimulus changes the inputs only on falling edges. Random offsets are pulled toward the effective limit, and the present bit is usually set, so that limit and permission outcomes come up often and are not hidden by not-present faults.

// File: rtl/seg_guard.sv
module seg_guard #(
  parameter int AW    = 32,
  parameter int LIMW  = 20,
  parameter int PAGEB = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [31:0]   seg_base,
  input  logic [19:0]   seg_limit,
  input  logic          seg_gran,
  input  logic          seg_big,
  input  logic [7:0]    seg_rights,
  input  logic [31:0]   acc_offset,
  input  logic [1:0]    acc_size,
  input  logic [1:0]    acc_kind,
  output logic [31:0]   lin_addr,
  output logic          fault,
  output logic [2:0]    fault_code
);
  localparam int XW = AW + 1;
  localparam logic [2:0] C_NONE = 3'd0, C_ABSENT = 3'd1, C_LIMIT = 3'd2,
                         C_WRITE = 3'd3, C_READ = 3'd4, C_EXEC = 3'd5;

  logic [AW-1:0] eff_lim;
  logic [XW-1:0] last_b, upper;
  logic          is_code, exp_dn, lim_bad, is_wr, is_fx;
  logic [2:0]    code_d;

  assign eff_lim = seg_gran ? {seg_limit, {PAGEB{1'b1}}} : {{(AW-LIMW){1'b0}}, seg_limit};
  assign last_b  = {1'b0, acc_offset} + (XW'(1) << acc_size) - XW'(1);
  assign upper   = seg_big ? {1'b0, {AW{1'b1}}} : XW'(16'hFFFF);
  assign is_code = seg_rights[3];
  assign exp_dn  = !is_code && seg_rights[2];
  assign is_wr   = (acc_kind == 2'd1);
  assign is_fx   = (acc_kind == 2'd2);
  assign lim_bad = exp_dn ? ((acc_offset <= eff_lim) || (last_b > upper))
                          : (last_b > {1'b0, eff_lim});

  always_comb begin
    if (!seg_rights[7])                        code_d = C_ABSENT;
    else if (is_code && is_wr)                 code_d = C_WRITE;
    else if (is_code && !is_fx && !is_wr && !seg_rights[1]) code_d = C_READ;
    else if (!is_code && is_wr && !seg_rights[1]) code_d = C_WRITE;
    else if (!is_code && is_fx)                code_d = C_EXEC;
    else if (lim_bad)                          code_d = C_LIMIT;
    else                                       code_d = C_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lin_addr   <= '0;
      fault      <= 1'b0;
      fault_code <= C_NONE;
    end else begin
      lin_addr   <= seg_base + acc_offset;
      fault      <= (code_d != C_NONE);
      fault_code <= code_d;
    end
  end
endmodule

// File: rtl/seg_guard_checker.sv
module seg_guard_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] seg_base,
  input logic [7:0]  seg_rights,
  input logic [31:0] acc_offset,
  input logic [1:0]  acc_kind,
  input logic [31:0] lin_addr,
  input logic        fault,
  input logic [2:0]  fault_code
);
  assert_flag_matches_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fault == (fault_code != 3'd0));

  assert_code_in_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fault_code <= 3'd5);

  assert_absent_faults_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(seg_rights[7])) |-> (fault_code == 3'd1));

  assert_code_write_denied_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(seg_rights[7]) && $past(seg_rights[3]) && $past(acc_kind) == 2'd1)
      |-> (fault_code == 3'd3));

  assert_data_fetch_denied_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(seg_rights[7]) && !$past(seg_rights[3]) && $past(acc_kind) == 2'd2)
      |-> (fault_code == 3'd5));

  assert_linear_sum_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (lin_addr == $past(seg_base) + $past(acc_offset)));

  always @(negedge clk)
    if (!rst_n) assert_reset_clear_R2: assert (lin_addr == 32'd0 && !fault && fault_code == 3'd0);
endmodule

bind seg_guard seg_guard_checker u_seg_guard_checker (
  .clk(clk), .rst_n(rst_n), .seg_base(seg_base), .seg_rights(seg_rights),
  .acc_offset(acc_offset), .acc_kind(acc_kind), .lin_addr(lin_addr),
  .fault(fault), .fault_code(fault_code)
);

// File: tb/seg_guard_bench.sv
module seg_guard_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] seg_base = '0;
  logic [19:0] seg_limit = '0;
  logic        seg_gran = 1'b0, seg_big = 1'b0;
  logic [7:0]  seg_rights = '0;
  logic [31:0] acc_offset = '0;
  logic [1:0]  acc_size = '0, acc_kind = '0;
  logic [31:0] lin_addr;
  logic        fault;
  logic [2:0]  fault_code;

  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_guard u_seg_guard (
    .clk(clk), .rst_n(rst_n), .seg_base(seg_base), .seg_limit(seg_limit),
    .seg_gran(seg_gran), .seg_big(seg_big), .seg_rights(seg_rights),
    .acc_offset(acc_offset), .acc_size(acc_size), .acc_kind(acc_kind),
    .lin_addr(lin_addr), .fault(fault), .fault_code(fault_code)
  );

  function automatic logic [2:0] ref_code();
    logic [32:0] lim, last, top;
    bit code_seg, down;
    lim  = seg_gran ? {1'b0, seg_limit, 12'hFFF} : {13'd0, seg_limit};
    last = {1'b0, acc_offset} + (33'd1 << acc_size) - 33'd1;
    top  = seg_big ? 33'h0_FFFF_FFFF : 33'h0_0000_FFFF;
    code_seg = seg_rights[3];
    down = !code_seg && seg_rights[2];
    if (!seg_rights[7]) return 3'd1;
    if (code_seg) begin
      if (acc_kind == 2'd1) return 3'd3;
      if (acc_kind != 2'd2 && !seg_rights[1]) return 3'd4;
    end else begin
      if (acc_kind == 2'd1 && !seg_rights[1]) return 3'd3;
      if (acc_kind == 2'd2) return 3'd5;
    end
    if (down) begin
      if ({1'b0, acc_offset} <= lim || last > top) return 3'd2;
    end else if (last > lim) return 3'd2;
    return 3'd0;
  endfunction

  function automatic string tag_of(logic [2:0] c);
    case (c)
      3'd1: return "R7";
      3'd2: return (!seg_rights[3] && seg_rights[2]) ? "R6" : "R5";
      3'd3, 3'd4: return seg_rights[3] ? "R8" : "R9";
      3'd5: return "R9";
      default: return seg_gran ? "R4" : "R3";
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(logic [31:0] b, logic [19:0] l, logic g, logic d, logic [7:0] r,
                       logic [31:0] o, logic [1:0] s, logic [1:0] k);
    logic [2:0] ec;
    logic [31:0] ea;
    string t;
    @(negedge clk);
    seg_base = b; seg_limit = l; seg_gran = g; seg_big = d; seg_rights = r;
    acc_offset = o; acc_size = s; acc_kind = k;
    #1;
    ec = ref_code(); ea = b + o; t = tag_of(ec);
    @(posedge clk); #1;
    check(t, {29'd0, fault_code}, {29'd0, ec});
    check("R10", {31'd0, fault}, {31'd0, ec != 3'd0});
    check("R1", lin_addr, ea);
  endtask

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'h5E6D_0042);
    seg_base = 32'hDEAD_BEEF; acc_offset = 32'h1234;
    repeat (3) @(posedge clk);
    #1;
    check("R2", lin_addr, 32'd0);
    check("R2", {29'd0, fault, fault_code}, 32'd0);
    @(negedge clk); rst_n = 1'b1;

    // R3 byte limit: last byte exactly at limit, then one past
    apply(32'h0010_0000, 20'h001FF, 1'b0, 1'b0, 8'h92, 32'h1FF, 2'd0, 2'd0);
    apply(32'h0010_0000, 20'h001FF, 1'b0, 1'b0, 8'h92, 32'h200, 2'd0, 2'd0);
    // R5 width crossing limit
    apply(32'h0010_0000, 20'h001FF, 1'b0, 1'b0, 8'h92, 32'h1FC, 2'd2, 2'd0);
    apply(32'h0010_0000, 20'h001FF, 1'b0, 1'b0, 8'h92, 32'h1FD, 2'd2, 2'd0);
    apply(32'h0010_0000, 20'h001FF, 1'b0, 1'b0, 8'h92, 32'h1F8, 2'd3, 2'd1);
    // R4 4K granularity
    apply(32'h1000_0000, 20'h001FF, 1'b1, 1'b1, 8'h92, 32'h001F_FFFF, 2'd0, 2'd0);
    apply(32'h1000_0000, 20'h001FF, 1'b1, 1'b1, 8'h92, 32'h0020_0000, 2'd0, 2'd0);
    apply(32'h0000_0010, 20'hFFFFF, 1'b1, 1'b1, 8'h92, 32'hFFFF_FFFC, 2'd2, 2'd0);
    apply(32'h0000_0010, 20'hFFFFF, 1'b1, 1'b1, 8'h92, 32'hFFFF_FFFD, 2'd2, 2'd0);
    // R6 expand-down
    apply(32'h0, 20'h00100, 1'b0, 1'b0, 8'h96, 32'h100, 2'd0, 2'd0);
    apply(32'h0, 20'h00100, 1'b0, 1'b0, 8'h96, 32'h101, 2'd0, 2'd1);
    apply(32'h0, 20'h00100, 1'b0, 1'b0, 8'h96, 32'hFFFF, 2'd0, 2'd0);
    apply(32'h0, 20'h00100, 1'b0, 1'b0, 8'h96, 32'hFFFE, 2'd1, 2'd0);
    apply(32'h0, 20'h00100, 1'b0, 1'b0, 8'h96, 32'h10000, 2'd0, 2'd0);
    apply(32'h0, 20'h00100, 1'b0, 1'b1, 8'h96, 32'h10000, 2'd0, 2'd0);
    // R7 absent beats everything
    apply(32'h5, 20'h0, 1'b0, 1'b0, 8'h1A, 32'hFFFF_FFFF, 2'd3, 2'd1);
    // R8 code segment
    apply(32'h0, 20'hFFFFF, 1'b0, 1'b0, 8'h9A, 32'h10, 2'd0, 2'd1);
    apply(32'h0, 20'hFFFFF, 1'b0, 1'b0, 8'h98, 32'h10, 2'd0, 2'd0);
    apply(32'h0, 20'hFFFFF, 1'b0, 1'b0, 8'h98, 32'h10, 2'd0, 2'd2);
    apply(32'h0, 20'hFFFFF, 1'b0, 1'b0, 8'h9A, 32'h10, 2'd0, 2'd3);
    // R9 data segment
    apply(32'h0, 20'hFFFFF, 1'b0, 1'b0, 8'h90, 32'h10, 2'd0, 2'd1);
    apply(32'h0, 20'hFFFFF, 1'b0, 1'b0, 8'h92, 32'h10, 2'd0, 2'd2);
    // R10 permission before limit
    apply(32'h0, 20'h0000F, 1'b0, 1'b0, 8'h90, 32'h100, 2'd0, 2'd1);

    for (int i = 0; i < 2000; i++) begin
      logic [19:0] l;
      logic g;
      logic [7:0] r;
      logic [31:0] o, lim;
      l = $urandom;
      g = $urandom_range(0, 1);
      r = $urandom;
      if ($urandom_range(0, 7) != 0) r[7] = 1'b1;
      lim = g ? {l, 12'hFFF} : {12'd0, l};
      o = ($urandom_range(0, 3) == 0) ? $urandom : lim + 32'($signed(5'($urandom)));
      apply($urandom, l, g, 1'($urandom), r, o, 2'($urandom), 2'($urandom));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule